// File: doc/BRIEF.md
# Double-Buffered PWM Compare Register

This block holds the compare values that a PWM time base uses, for two channels, A and B. Each channel keeps a shadow register and an active register. The active register drives the compare stage. Every value is a coarse compare half in the upper bits and a fine-resolution extension in the lower bits. A CPU write port can update either half or both, and a read port returns the control word or a channel's value.

The control word picks a mode for each channel. In immediate mode, writes go straight into the active register. In double-buffered mode, writes land in the shadow register, and the whole value moves to the active register in one step when a load strobe fires. The load strobe comes from the time-base events (counter at zero, counter at period), from an external SYNC pulse, or from both, as the control word selects. A per-channel pending flag shows that the shadow holds a value that has not been loaded yet.

Top module: `pwm_cmp_dbuf`

## Requirements
- R1: After reset, the control word, both shadow registers, both active registers and both pending flags are 0.
- R2: The control word is read and written at address 0, using data bits 15:0. Its fields are:
  - bits 1:0: channel A event select
  - bits 3:2: channel B event select
  - bit 4: channel A immediate mode
  - bit 6: channel B immediate mode
  - bits 11:10: channel A SYNC select
  - bits 13:12: channel B SYNC select
  - bit 8: channel A pending flag, read-only
  - bit 9: channel B pending flag, read-only

  All other bits read 0, and writes to them or to bits 9:8 have no effect.
- R3: The event select decides which counter events cause a load:
  - 00: counter-zero only
  - 01: counter-period only
  - 10: either event
  - 11: no counter event
- R4: The SYNC select decides how SYNC combines with the counter events:
  - 00: counter events only
  - 01: counter events or SYNC
  - 10: SYNC only
  - 11: behaves as 00
- R5: In double-buffered mode (mode bit 0), a write at address 1 (A) or 2 (B) changes only the shadow register. On the clock edge where a load strobe is active, the complete value (compare bits 31:16 and extension bits 15:0) is copied from shadow to active. The new value appears on the active output in the next cycle.
- R6: In immediate mode (mode bit 1), a write updates the active output in the next cycle. Counter events and SYNC leave the active value unchanged, and the pending flag is not changed.
- R7: In double-buffered mode, a write with the compare-half enable set sets the pending flag, whether or not the extension half is also written. A write with only the extension-half enable set changes bits 15:0 of the shadow and leaves the flag as it was.
- R8: A load strobe clears the pending flag, unless a compare-half write happens in the same cycle.
- R9: A write while the pending flag is set replaces the pending shadow value, and the next load transfers the newer value.
- R10: When a write and a load strobe happen in the same cycle, the previous shadow value becomes active. The written value stays in the shadow, and the pending flag ends up set if the write enabled the compare half.
- R11: A read at a channel's address returns its shadow register in double-buffered mode and its active register in immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 channel A, 2 channel B |
| wr_cmp_en_i | input | 1 | Write the compare half (bits 31:16) of a channel |
| wr_ext_en_i | input | 1 | Write the extension half (bits 15:0) of a channel |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 32 | Read data, combinational |
| ctr_zero_i | input | 1 | Time-base counter-equals-zero strobe |
| ctr_prd_i | input | 1 | Time-base counter-equals-period strobe |
| sync_i | input | 1 | External SYNC pulse |
| act_a_o | output | 32 | Active compare value, channel A |
| act_b_o | output | 32 | Active compare value, channel B |
| full_a_o | output | 1 | Channel A shadow pending flag |
| full_b_o | output | 1 | Channel B shadow pending flag |

## Verification
A corrupted shadow register does not show on the active output until the next load strobe. For that reason, the bench also reads the shadow back through the read port in the cycle after each write, and compares it again after the load. A wrongly decoded event or SYNC select shows as an active value that changes, or fails to change, in the cycle right after the strobe, together with a pending flag that stays set or clears out of turn. A mishandled write in the same cycle as a strobe shows one cycle later: either the new value appears on the active output too early, or the pending flag reads 0.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int CTRL_W = 16;

  localparam logic [1:0] ADDR_CTRL = 2'd0;

  typedef enum logic [1:0] {
    EV_ZERO = 2'b00,
    EV_PRD  = 2'b01,
    EV_BOTH = 2'b10,
    EV_OFF  = 2'b11
  } ev_sel_e;

  typedef enum logic [1:0] {
    SY_NONE = 2'b00,
    SY_ALSO = 2'b01,
    SY_ONLY = 2'b10,
    SY_RSVD = 2'b11
  } sy_sel_e;

  typedef struct packed {
    ev_sel_e ev;
    logic    imm;
    sy_sel_e sy;
  } ch_cfg_t;

  function automatic ch_cfg_t cfg_from_word(logic [CTRL_W-1:0] w, int ch);
    ch_cfg_t c;
    if (ch == 0) begin
      c.ev  = ev_sel_e'(w[1:0]);
      c.imm = w[4];
      c.sy  = sy_sel_e'(w[11:10]);
    end else begin
      c.ev  = ev_sel_e'(w[3:2]);
      c.imm = w[6];
      c.sy  = sy_sel_e'(w[13:12]);
    end
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] word_from_cfg(ch_cfg_t a, ch_cfg_t b,
                                                      logic fa, logic fb);
    logic [CTRL_W-1:0] w;
    w        = '0;
    w[1:0]   = a.ev;
    w[3:2]   = b.ev;
    w[4]     = a.imm;
    w[6]     = b.imm;
    w[8]     = fa;
    w[9]     = fb;
    w[11:10] = a.sy;
    w[13:12] = b.sy;
    return w;
  endfunction
endpackage

// File: rtl/pwm_cmp_ldsel.sv
module pwm_cmp_ldsel
  import pwm_cmp_pkg::*;
(
  input  ch_cfg_t cfg_i,
  input  logic    zero_i,
  input  logic    prd_i,
  input  logic    sync_i,
  output logic    load_o
);
  logic ev_hit;
  logic ld;

  always_comb begin
    unique case (cfg_i.ev)
      EV_ZERO: ev_hit = zero_i;
      EV_PRD:  ev_hit = prd_i;
      EV_BOTH: ev_hit = zero_i | prd_i;
      default: ev_hit = 1'b0;
    endcase
    unique case (cfg_i.sy)
      SY_ALSO: ld = ev_hit | sync_i;
      SY_ONLY: ld = sync_i;
      default: ld = ev_hit;  // reserved code acts as event-only
    endcase
    load_o = ld & ~cfg_i.imm;
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int CMP_W = 16,
  parameter int EXT_W = 16,
  localparam int VAL_W = CMP_W + EXT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             imm_i,
  input  logic             load_i,
  input  logic             wr_i,
  input  logic             cmp_en_i,
  input  logic             ext_en_i,
  input  logic [VAL_W-1:0] data_i,
  output logic [VAL_W-1:0] act_o,
  output logic [VAL_W-1:0] shd_o,
  output logic             full_o
);
  logic [VAL_W-1:0] act_q, shd_q, base, merged;
  logic             full_q;

  // half-selective merge onto whichever register the write targets
  assign base   = imm_i ? act_q : shd_q;
  assign merged = {cmp_en_i ? data_i[VAL_W-1:EXT_W] : base[VAL_W-1:EXT_W],
                   ext_en_i ? data_i[EXT_W-1:0]     : base[EXT_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      shd_q  <= '0;
      full_q <= 1'b0;
    end else if (imm_i) begin
      if (wr_i) act_q <= merged;
    end else begin
      if (load_i) act_q <= shd_q;
      if (wr_i) shd_q <= merged;
      if (wr_i && cmp_en_i) full_q <= 1'b1;
      else if (load_i)      full_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign shd_o  = shd_q;
  assign full_o = full_q;

  assert_load_xfer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && load_i) |=> act_q == $past(shd_q));
  assert_full_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && wr_i && cmp_en_i) |=> full_q);
  assert_full_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && load_i && !(wr_i && cmp_en_i)) |=> !full_q);
  assert_ext_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && wr_i && !cmp_en_i && !load_i) |=> full_q == $past(full_q));
  assert_imm_shd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_i |=> ($stable(shd_q) && $stable(full_q)));
endmodule

// File: rtl/pwm_cmp_dbuf.sv
module pwm_cmp_dbuf
  import pwm_cmp_pkg::*;
#(
  parameter int CMP_W = 16,
  parameter int EXT_W = 16,
  localparam int VAL_W = CMP_W + EXT_W,
  localparam int NCH   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic             wr_cmp_en_i,
  input  logic             wr_ext_en_i,
  input  logic [VAL_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [VAL_W-1:0] rd_data_o,
  input  logic             ctr_zero_i,
  input  logic             ctr_prd_i,
  input  logic             sync_i,
  output logic [VAL_W-1:0] act_a_o,
  output logic [VAL_W-1:0] act_b_o,
  output logic             full_a_o,
  output logic             full_b_o
);
  ch_cfg_t          cfg_q  [NCH];
  logic [VAL_W-1:0] act    [NCH];
  logic [VAL_W-1:0] shd    [NCH];
  logic [VAL_W-1:0] view   [NCH];
  logic             full   [NCH];
  logic             load   [NCH];
  logic             wr_hit [NCH];
  logic             ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cfg_q[i] <= '0;
      else if (ctrl_wr) cfg_q[i] <= cfg_from_word(wr_data_i[CTRL_W-1:0], i);
    end

    assign wr_hit[i] = wr_en_i && (wr_addr_i == 2'(i + 1));

    pwm_cmp_ldsel u_ldsel (
      .cfg_i  (cfg_q[i]),
      .zero_i (ctr_zero_i),
      .prd_i  (ctr_prd_i),
      .sync_i (sync_i),
      .load_o (load[i])
    );

    pwm_cmp_chan #(.CMP_W(CMP_W), .EXT_W(EXT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .imm_i    (cfg_q[i].imm),
      .load_i   (load[i]),
      .wr_i     (wr_hit[i]),
      .cmp_en_i (wr_cmp_en_i),
      .ext_en_i (wr_ext_en_i),
      .data_i   (wr_data_i),
      .act_o    (act[i]),
      .shd_o    (shd[i]),
      .full_o   (full[i])
    );

    assign view[i] = cfg_q[i].imm ? act[i] : shd[i];
  end

  always_comb begin
    unique case (rd_addr_i)
      2'd0:    rd_data_o = VAL_W'(word_from_cfg(cfg_q[0], cfg_q[1], full[0], full[1]));
      2'd1:    rd_data_o = view[0];
      2'd2:    rd_data_o = view[1];
      default: rd_data_o = '0;
    endcase
  end

  assign act_a_o  = act[0];
  assign act_b_o  = act[1];
  assign full_a_o = full[0];
  assign full_b_o = full[1];

  assert_imm_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[0].imm && wr_hit[0] && wr_cmp_en_i)
      |=> act_a_o[VAL_W-1:EXT_W] == $past(wr_data_i[VAL_W-1:EXT_W]));
  assert_ctrl_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == ADDR_CTRL) |-> (rd_data_o[15:14] == 2'b00 && rd_data_o[7] == 1'b0
                                  && rd_data_o[5] == 1'b0 && rd_data_o[VAL_W-1:16] == '0));
  assert_no_load_imm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[1].imm && !wr_hit[1]) |=> $stable(act_b_o));
endmodule

// File: tb/sim_pwm_cmp_dbuf.sv
module sim_pwm_cmp_dbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_cmp = 0, wr_ext = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data, act_a, act_b;
  logic        zero = 0, prd = 0, sync = 0;
  logic        full_a, full_b;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pwm_cmp_dbuf u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_cmp_en_i(wr_cmp), .wr_ext_en_i(wr_ext), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ctr_zero_i(zero),
    .ctr_prd_i(prd), .sync_i(sync), .act_a_o(act_a), .act_b_o(act_b),
    .full_a_o(full_a), .full_b_o(full_b)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  // drive one cycle of stimulus after a negedge; outputs settle by the next negedge
  task automatic step(logic we, logic [1:0] a, logic c, logic e, logic [31:0] d,
                      logic z, logic p, logic s);
    wr_en = we; wr_addr = a; wr_cmp = c; wr_ext = e; wr_data = d;
    zero = z; prd = p; sync = s;
    @(negedge clk);
    wr_en = 0; wr_cmp = 0; wr_ext = 0; zero = 0; prd = 0; sync = 0;
  endtask

  task automatic wctl(logic [15:0] v); step(1, 0, 0, 0, {16'h0, v}, 0, 0, 0); endtask
  task automatic wval(logic [1:0] a, logic [31:0] v); step(1, a, 1, 1, v, 0, 0, 0); endtask
  task automatic pulse(logic z, logic p, logic s); step(0, 0, 0, 0, 0, z, p, s); endtask
  task automatic flush(); wctl(16'h0); pulse(1, 0, 0); endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 act_a", act_a, 0); chk("R1 act_b", act_b, 0);
    chk("R1 full_a", {31'h0, full_a}, 0); chk("R1 full_b", {31'h0, full_b}, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 shadow a", v, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wctl(16'hFFFF);
    rd(0, v); chk("R2 ctrl rsvd/ro", v, 32'h0000_3C5F);
    wctl(16'h0000);
    wval(1, 32'h0101_0202);
    rd(0, v); chk("R2 flag a bit8", v, 32'h0000_0100);
    flush();
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    flush();
    wval(1, 32'h1234_5678);
    chk("R5 act held", act_a, 32'h0101_0202);
    chk("R7 full set", {31'h0, full_a}, 1);
    rd(1, v); chk("R11 shadow view", v, 32'h1234_5678);
    pulse(0, 1, 0); chk("R3 ev00 ignores period", act_a, 32'h0101_0202);
    pulse(0, 0, 1); chk("R4 sy00 ignores sync", act_a, 32'h0101_0202);
    pulse(1, 0, 0); chk("R5 load on zero", act_a, 32'h1234_5678);
    chk("R8 full clear", {31'h0, full_a}, 0);
  endtask

  task automatic t_ev();
    flush();
    wctl(16'h0001); wval(1, 32'hA000_0001);
    pulse(1, 0, 0); chk("R3 ev01 ignores zero", act_a, 32'h1234_5678);
    pulse(0, 1, 0); chk("R3 ev01 period", act_a, 32'hA000_0001);
    wctl(16'h0002); wval(1, 32'hA000_0002);
    pulse(1, 0, 0); chk("R3 ev10 zero", act_a, 32'hA000_0002);
    wval(1, 32'hA000_0003);
    pulse(0, 1, 0); chk("R3 ev10 period", act_a, 32'hA000_0003);
    wctl(16'h0003); wval(1, 32'hA000_0004);
    pulse(1, 1, 0); chk("R3 ev11 frozen", act_a, 32'hA000_0003);
    chk("R3 ev11 full stays", {31'h0, full_a}, 1);
  endtask

  task automatic t_sync();
    flush();  // act_a = A0000004
    wctl(16'h0400); wval(1, 32'hB000_0001);
    pulse(0, 0, 1); chk("R4 sy01 sync", act_a, 32'hB000_0001);
    wval(1, 32'hB000_0002);
    pulse(1, 0, 0); chk("R4 sy01 zero", act_a, 32'hB000_0002);
    wctl(16'h0800); wval(1, 32'hB000_0003);
    pulse(1, 0, 0); chk("R4 sy10 ignores zero", act_a, 32'hB000_0002);
    pulse(0, 0, 1); chk("R4 sy10 sync", act_a, 32'hB000_0003);
    wctl(16'h0C00); wval(1, 32'hB000_0004);
    pulse(0, 0, 1); chk("R4 sy11 ignores sync", act_a, 32'hB000_0003);
    pulse(1, 0, 0); chk("R4 sy11 zero", act_a, 32'hB000_0004);
  endtask

  task automatic t_halves();
    logic [31:0] v;
    flush();
    wval(1, 32'hAAAA_5555); pulse(1, 0, 0);
    step(1, 1, 0, 1, 32'h0000_1111, 0, 0, 0);
    chk("R7 ext-only keeps flag", {31'h0, full_a}, 0);
    rd(1, v); chk("R7 ext-only shadow", v, 32'hAAAA_1111);
    step(1, 1, 1, 0, 32'h2222_0000, 0, 0, 0);
    chk("R7 cmp-only sets flag", {31'h0, full_a}, 1);
    pulse(1, 0, 0); chk("R5 atomic load", act_a, 32'h2222_1111);
  endtask

  task automatic t_overwrite();
    flush();
    wval(1, 32'hC000_0001); wval(1, 32'hC000_0002);
    chk("R9 full still set", {31'h0, full_a}, 1);
    pulse(1, 0, 0); chk("R9 newer value loaded", act_a, 32'hC000_0002);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    flush();
    wval(1, 32'hD000_0001);
    step(1, 1, 1, 1, 32'hD000_0002, 1, 0, 0);
    chk("R10 old shadow active", act_a, 32'hD000_0001);
    chk("R10 flag set", {31'h0, full_a}, 1);
    rd(1, v); chk("R10 new in shadow", v, 32'hD000_0002);
    pulse(1, 0, 0); chk("R10 follow-up load", act_a, 32'hD000_0002);
  endtask

  task automatic t_imm();
    logic [31:0] v;
    flush();
    wctl(16'h0412);
    wval(1, 32'hCAFE_0001);
    chk("R6 imm write", act_a, 32'hCAFE_0001);
    chk("R6 imm no flag", {31'h0, full_a}, 0);
    rd(1, v); chk("R11 imm view", v, 32'hCAFE_0001);
    pulse(1, 1, 1); chk("R6 imm ignores strobes", act_a, 32'hCAFE_0001);
    step(1, 1, 0, 1, 32'h0000_BEEF, 0, 0, 0);
    chk("R6 imm ext half", act_a, 32'hCAFE_BEEF);
  endtask

  task automatic t_chan_b();
    logic [31:0] b0;
    flush();
    b0 = act_b;
    wctl(16'h0004); wval(2, 32'h0B0B_0B0B);
    chk("R7 full_b set", {31'h0, full_b}, 1);
    chk("R7 full_a untouched", {31'h0, full_a}, 0);
    pulse(1, 0, 0); chk("R3 b ev01 ignores zero", act_b, b0);
    pulse(0, 1, 0); chk("R3 b period", act_b, 32'h0B0B_0B0B);
    wctl(16'h2000); wval(2, 32'h0C0C_0C0C);
    pulse(0, 0, 1); chk("R4 b sync only", act_b, 32'h0C0C_0C0C);
    wctl(16'h0040); wval(2, 32'h0D0D_0D0D);
    chk("R6 b imm write", act_b, 32'h0D0D_0D0D);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_shadow();
    t_ev();
    t_sync();
    t_halves();
    t_overwrite();
    t_same_cycle();
    t_imm();
    t_chan_b();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule